// File: doc/BRIEF.md
# SATA Transport Control Register Bank

This block is the processor-facing register bank of a SATA frame-transfer engine. A simple single-cycle CPU bus with a byte offset, read and write strobes and 32-bit data reaches it. Through the bus, software sets three sector-aligned DDR base addresses. One is for frames to send, one for received frames that carry no data, and one for received data frames. Software then writes a control word that gives the transfer length, says whether the frame is a data frame, and starts the transfer or resets the engine.

In the other direction, the transfer datapaths report events back to the bank. They pulse a line for each received 32-bit word, report frame completion together with the frame's type, report the end of a transmission, and deliver an error code. The bank counts the received words, latches the type of the last frame and the error code, and keeps two pending interrupt flags. One flag is raised by the engine for the CPU and the other is raised by the CPU's own start command. Each flag has its own write-one-to-clear bit.

Top module: `sata_xport_regbank`

## Requirements
- R1: After reset, all three address outputs are zero, `xfer_start`, `xfer_is_data`, `xfer_len`, `eng_rst` and `irq` are 0, and reads of offsets 0x04 and 0x0C return 0.
- R2: A write to offset 0x00 (transmit area), 0x04 (non-data receive area) or 0x0C (data receive area) stores the written value on `tx_addr`, `rxnd_addr` or `rxd_addr` respectively with bits 8:0 forced to zero, visible after the write's clock edge.
- R3: A write to offset 0x08 (control word) loads `xfer_len` from bits 15:0 and `xfer_is_data` from bit 29 (1 = data frame); both hold until the next control write or engine reset.
- R4: `xfer_start` is high for exactly the one cycle after a control write with bit 30 = 1 and bit 31 = 0; any other control write leaves it low.
- R5: Each cycle with `rx_word_inc` high adds one to a 24-bit receive count, read in bits 23:0 of offset 0x0C; any control write zeroes it, and the clear takes precedence over an increment in the same cycle.
- R6: `rx_frame_done` with `rx_frame_nondata` = 1 sets bit 31 of offset 0x0C (1 = non-data frame); a completion of a data frame leaves it unchanged; writing 1 to bit 29 of offset 0x10 clears it, and a set in the same cycle wins.
- R7: `err_valid` latches `err_code`, returned zero-extended in bits 7:0 of offset 0x04 until replaced.
- R8: An engine flag is set by `tx_done` or `rx_frame_done` and cleared by writing 1 to bit 31 of offset 0x10; a CPU flag is set in the cycle after the start pulse and cleared by bit 30 of offset 0x10; `irq` is high while either flag is set, and a set in the same cycle as its clear wins.
- R9: A control write with bit 31 = 1 pulses `eng_rst` for one cycle and, one cycle after the write, zeroes the receive count, type flag, error code, both interrupt flags, `xfer_len` and `xfer_is_data`, overriding any event in that cycle; the three address registers keep their values and no start pulse is issued.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd`; offsets other than 0x04 and 0x0C read as 0, and `bus_rdata` is 0 in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_addr | output | 32 | Transmit frame area base address |
| rxnd_addr | output | 32 | Non-data receive area base address |
| rxd_addr | output | 32 | Data-frame receive area base address |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_is_data | output | 1 | Frame to send is a data frame |
| xfer_len | output | 16 | Transmit length in 32-bit words |
| eng_rst | output | 1 | One-cycle engine reset strobe |
| tx_done | input | 1 | Transmission finished |
| rx_word_inc | input | 1 | One received 32-bit word |
| rx_frame_done | input | 1 | Received frame complete |
| rx_frame_nondata | input | 1 | Type of the completed frame, 1 = non-data |
| err_valid | input | 1 | Error code valid strobe |
| err_code | input | 8 | Error code from the link layer |
| irq | output | 1 | Interrupt, either flag pending |

## Verification
The assertions assume that the bus issues at most one of read or write per cycle and that the engine event inputs are single-cycle strobes, sampled on the rising edge. They also assume that no bus access arrives during the two cycles of internal reset release. The bench drives every input right after a falling edge and holds it for exactly one cycle. It waits several cycles after reset before the first access and never asserts read and write together. Coincident events such as an increment with a count clear, or a flag set with its clear, are produced deliberately by raising both strobes in the same cycle.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  localparam int SXR_DW    = 32;
  localparam int SXR_AW    = 5;
  localparam int SXR_ALIGN = 9;

  localparam logic [SXR_AW-1:0] OFS_TX_ADDR   = 5'h00;
  localparam logic [SXR_AW-1:0] OFS_RXND_ADDR = 5'h04;
  localparam logic [SXR_AW-1:0] OFS_CTRL      = 5'h08;
  localparam logic [SXR_AW-1:0] OFS_RXD_ADDR  = 5'h0C;
  localparam logic [SXR_AW-1:0] OFS_CLEAR     = 5'h10;

  localparam logic [SXR_AW-1:0] OFS_RD_ERR    = 5'h04;
  localparam logic [SXR_AW-1:0] OFS_RD_COUNT  = 5'h0C;

  localparam int CTL_HWRST_BIT = 31;
  localparam int CTL_START_BIT = 30;
  localparam int CTL_DATA_BIT  = 29;

  localparam int CLR_ENG_BIT   = 31;
  localparam int CLR_CPU_BIT   = 30;
  localparam int CLR_TYPE_BIT  = 29;

  localparam int NUM_ADDR = 3;
  localparam int NUM_FLAG = 2;

  typedef enum logic [1:0] {
    AREA_TX   = 2'd0,
    AREA_RXND = 2'd1,
    AREA_RXD  = 2'd2
  } area_e;

  typedef enum logic {
    FLAG_ENG = 1'b0,
    FLAG_CPU = 1'b1
  } flag_e;
endpackage

// File: rtl/sxr_rst_sync.sv
module sxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sxr_addr_reg.sv
module sxr_addr_reg #(
  parameter int DW    = 32,
  parameter int ALIGN = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DW-ALIGN-1:0] wdata_hi,
  output logic [DW-1:0]    q
);
  logic [DW-ALIGN-1:0] hi_q;
  logic [DW-ALIGN-1:0] hi_d;

  always_comb begin
    hi_d = hi_q;
    if (we) hi_d = wdata_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  assign q = {hi_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/sxr_ctrl.sv
module sxr_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             hw_bit,
  input  logic             start_bit,
  input  logic             data_bit,
  input  logic [LEN_W-1:0] len_in,
  output logic             start_o,
  output logic             is_data_o,
  output logic [LEN_W-1:0] len_o,
  output logic             hwrst_o
);
  logic             start_q, start_d;
  logic             data_q, data_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             hwrst_q, hwrst_d;

  always_comb begin
    data_d  = data_q;
    len_d   = len_q;
    hwrst_d = ctrl_we & hw_bit;
    start_d = ctrl_we & start_bit & ~hw_bit & ~hwrst_q;
    if (hwrst_q) begin
      data_d = 1'b0;
      len_d  = '0;
    end else if (ctrl_we) begin
      data_d = data_bit;
      len_d  = len_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      data_q  <= 1'b0;
      len_q   <= '0;
      hwrst_q <= 1'b0;
    end else begin
      start_q <= start_d;
      data_q  <= data_d;
      len_q   <= len_d;
      hwrst_q <= hwrst_d;
    end
  end

  assign start_o   = start_q;
  assign is_data_o = data_q;
  assign len_o     = len_q;
  assign hwrst_o   = hwrst_q;
endmodule

// File: rtl/sxr_status.sv
module sxr_status #(
  parameter int CNT_W = 24,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             cnt_clr,
  input  logic             word_inc,
  input  logic             frame_done,
  input  logic             frame_nondata,
  input  logic             type_clr,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_code,
  output logic [CNT_W-1:0] cnt_o,
  output logic             type_o,
  output logic [ERR_W-1:0] err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             type_q, type_d;
  logic [ERR_W-1:0] err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_all || cnt_clr) cnt_d = '0;
    else if (word_inc)      cnt_d = cnt_q + CNT_W'(1);

    type_d = type_q;
    if (clr_all)                         type_d = 1'b0;
    else if (frame_done && frame_nondata) type_d = 1'b1;
    else if (type_clr)                   type_d = 1'b0;

    err_d = err_q;
    if (clr_all)        err_d = '0;
    else if (err_valid) err_d = err_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= 1'b0;
      err_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      type_q <= type_d;
      err_q  <= err_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign type_o = type_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sxr_irq.sv
module sxr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr_all)       flag_d[g] = 1'b0;
      else if (set_i[g]) flag_d[g] = 1'b1;
      else if (clr_i[g]) flag_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sata_xport_regbank.sv
module sata_xport_regbank
  import sxr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 24,
  parameter int ERR_W  = 8,
  parameter int ALIGN  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     tx_addr,
  output logic [DW-1:0]     rxnd_addr,
  output logic [DW-1:0]     rxd_addr,
  output logic              xfer_start,
  output logic              xfer_is_data,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              eng_rst,
  input  logic              tx_done,
  input  logic              rx_word_inc,
  input  logic              rx_frame_done,
  input  logic              rx_frame_nondata,
  input  logic              err_valid,
  input  logic [ERR_W-1:0]  err_code,
  output logic              irq
);
  localparam int HI_W = DW - ALIGN;

  logic                rst_ni;
  logic [NUM_ADDR-1:0] addr_we;
  logic [DW-1:0]       addr_q [NUM_ADDR];
  logic                we_ctrl, we_clr;
  logic [CNT_W-1:0]    rx_count;
  logic                rx_type;
  logic [ERR_W-1:0]    err_q;
  logic [NUM_FLAG-1:0] flag_set, flag_clr, flags;
  logic [DW-1:0]       rdata_q, rdata_d;

  sxr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_ni)
  );

  // write decode
  always_comb begin
    addr_we            = '0;
    addr_we[AREA_TX]   = bus_wr && (bus_addr == ADDR_W'(OFS_TX_ADDR));
    addr_we[AREA_RXND] = bus_wr && (bus_addr == ADDR_W'(OFS_RXND_ADDR));
    addr_we[AREA_RXD]  = bus_wr && (bus_addr == ADDR_W'(OFS_RXD_ADDR));
    we_ctrl            = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    we_clr             = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
  end

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_area
    sxr_addr_reg #(.DW(DW), .ALIGN(ALIGN)) u_area (
      .clk     (clk),
      .rst_n   (rst_ni),
      .we      (addr_we[g]),
      .wdata_hi(bus_wdata[DW-1:ALIGN]),
      .q       (addr_q[g])
    );
  end

  assign tx_addr   = addr_q[AREA_TX];
  assign rxnd_addr = addr_q[AREA_RXND];
  assign rxd_addr  = addr_q[AREA_RXD];

  sxr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .ctrl_we  (we_ctrl),
    .hw_bit   (bus_wdata[CTL_HWRST_BIT]),
    .start_bit(bus_wdata[CTL_START_BIT]),
    .data_bit (bus_wdata[CTL_DATA_BIT]),
    .len_in   (bus_wdata[LEN_W-1:0]),
    .start_o  (xfer_start),
    .is_data_o(xfer_is_data),
    .len_o    (xfer_len),
    .hwrst_o  (eng_rst)
  );

  sxr_status #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_ni),
    .clr_all      (eng_rst),
    .cnt_clr      (we_ctrl),
    .word_inc     (rx_word_inc),
    .frame_done   (rx_frame_done),
    .frame_nondata(rx_frame_nondata),
    .type_clr     (we_clr && bus_wdata[CLR_TYPE_BIT]),
    .err_valid    (err_valid),
    .err_code     (err_code),
    .cnt_o        (rx_count),
    .type_o       (rx_type),
    .err_o        (err_q)
  );

  always_comb begin
    flag_set           = '0;
    flag_clr           = '0;
    flag_set[FLAG_ENG] = tx_done || rx_frame_done;
    flag_set[FLAG_CPU] = xfer_start;
    flag_clr[FLAG_ENG] = we_clr && bus_wdata[CLR_ENG_BIT];
    flag_clr[FLAG_CPU] = we_clr && bus_wdata[CLR_CPU_BIT];
  end

  sxr_irq #(.N(NUM_FLAG)) u_irq (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr_all(eng_rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  assign irq = |flags;

  // registered read path
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_RD_ERR)) begin
        rdata_d[ERR_W-1:0] = err_q;
      end else if (bus_addr == ADDR_W'(OFS_RD_COUNT)) begin
        rdata_d[DW-1]      = rx_type;
        rdata_d[CNT_W-1:0] = rx_count;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/sxr_checker.sv
module sxr_checker #(
  parameter int DW     = 32,
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 24,
  parameter int ALIGN  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              w31,
  input logic              w30,
  input logic              w29,
  input logic [ALIGN-1:0]  tx_lo,
  input logic [ALIGN-1:0]  rxnd_lo,
  input logic [ALIGN-1:0]  rxd_lo,
  input logic              xfer_start,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              eng_rst,
  input logic              tx_done,
  input logic              rx_frame_done,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_type,
  input logic              irq
);
  logic ctrl_wr, clr_wr;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(5'h08));
  assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(5'h10));

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lo == '0) && (rxnd_lo == '0) && (rxd_lo == '0));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_start_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w30 && !w31 && !eng_rst) |=> xfer_start);

  assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (rx_count == '0));

  assert_type_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_type && !(clr_wr && w29) && !eng_rst) |=> rx_type);

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_done || rx_frame_done) && !eng_rst) |=> irq);

  assert_hwrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && w31) |-> ##2 ((rx_count == '0) && !rx_type && !irq && (xfer_len == '0)));

  assert_hwrst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !eng_rst);
endmodule

bind sata_xport_regbank sxr_checker #(
  .DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .ALIGN(ALIGN)
) u_sxr_checker (
  .clk          (clk),
  .rst_n        (rst_ni),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .w31          (bus_wdata[31]),
  .w30          (bus_wdata[30]),
  .w29          (bus_wdata[29]),
  .tx_lo        (tx_addr[ALIGN-1:0]),
  .rxnd_lo      (rxnd_addr[ALIGN-1:0]),
  .rxd_lo       (rxd_addr[ALIGN-1:0]),
  .xfer_start   (xfer_start),
  .xfer_len     (xfer_len),
  .eng_rst      (eng_rst),
  .tx_done      (tx_done),
  .rx_frame_done(rx_frame_done),
  .rx_count     (rx_count),
  .rx_type      (rx_type),
  .irq          (irq)
);

// File: tb/sata_xport_regbank_bench.sv
module sata_xport_regbank_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] tx_addr, rxnd_addr, rxd_addr;
  logic        xfer_start, xfer_is_data, eng_rst, irq;
  logic [15:0] xfer_len;
  logic        tx_done, rx_word_inc, rx_frame_done, rx_frame_nondata, err_valid;
  logic [7:0]  err_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen;

  sata_xport_regbank u_sata_xport_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_addr(tx_addr), .rxnd_addr(rxnd_addr),
    .rxd_addr(rxd_addr), .xfer_start(xfer_start), .xfer_is_data(xfer_is_data),
    .xfer_len(xfer_len), .eng_rst(eng_rst), .tx_done(tx_done), .rx_word_inc(rx_word_inc),
    .rx_frame_done(rx_frame_done), .rx_frame_nondata(rx_frame_nondata),
    .err_valid(err_valid), .err_code(err_code), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a read issued before a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read data %h expected none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tx_done = 0; rx_word_inc = 0; rx_frame_done = 0; rx_frame_nondata = 0;
    err_valid = 0; err_code = '0;
    idle(3); rst_n = 1; idle(5);

    // R1 reset state
    check(tx_addr | rxnd_addr | rxd_addr, 32'h0, "R1 addresses");
    check({xfer_start, xfer_is_data, eng_rst, irq}, 4'h0, "R1 strobes");
    check(32'(xfer_len), 32'h0, "R1 length");
    rd(5'h04, 32'h0, "R1 error read");
    rd(5'h0C, 32'h0, "R1 count read");

    // R2 aligned address writes
    wr(5'h00, 32'h8000_21FF); check(tx_addr,   32'h8000_2000, "R2 tx area");
    wr(5'h04, 32'h1234_5678); check(rxnd_addr, 32'h1234_5600, "R2 non-data area");
    wr(5'h0C, 32'h9000_0000); check(rxd_addr,  32'h9000_0000, "R2 data area");

    // R3/R4/R8 start a data transfer
    wr(5'h08, 32'h6000_0040);
    check(32'(xfer_start), 32'h1, "R4 start pulse");
    check(32'(xfer_is_data), 32'h1, "R3 data bit");
    check(32'(xfer_len), 32'h40, "R3 length");
    idle(1);
    check(32'(xfer_start), 32'h0, "R4 pulse one cycle");
    check(32'(irq), 32'h1, "R8 cpu flag raised");
    wr(5'h10, 32'h4000_0000);
    check(32'(irq), 32'h0, "R8 cpu flag cleared");

    // R3/R4 control write without start
    wr(5'h08, 32'h0000_0123);
    check(32'(xfer_start), 32'h0, "R4 no start");
    check(32'(xfer_is_data), 32'h0, "R3 non-data");
    check(32'(xfer_len), 32'h123, "R3 length 2");

    // R5 counting and clear on control write
    @(negedge clk); rx_word_inc = 1; idle(5); rx_word_inc = 0;
    rd(5'h0C, 32'h0000_0005, "R5 count five");
    @(negedge clk); rx_word_inc = 1; bus_addr = 5'h08; bus_wdata = 32'h0000_0001; bus_wr = 1;
    @(negedge clk); rx_word_inc = 0; bus_wr = 0;
    rd(5'h0C, 32'h0000_0000, "R5 clear beats increment");

    // R6 type flag
    @(negedge clk); rx_frame_done = 1; rx_frame_nondata = 1; rx_word_inc = 1;
    @(negedge clk); rx_frame_done = 0; rx_frame_nondata = 0; rx_word_inc = 0;
    rd(5'h0C, 32'h8000_0001, "R6 non-data latched");
    check(32'(irq), 32'h1, "R8 engine flag");
    @(negedge clk); rx_frame_done = 1; rx_frame_nondata = 0;
    @(negedge clk); rx_frame_done = 0;
    rd(5'h0C, 32'h8000_0001, "R6 data frame keeps flag");
    @(negedge clk); rx_frame_done = 1; rx_frame_nondata = 1;
    bus_addr = 5'h10; bus_wdata = 32'h2000_0000; bus_wr = 1;
    @(negedge clk); rx_frame_done = 0; rx_frame_nondata = 0; bus_wr = 0;
    rd(5'h0C, 32'h8000_0001, "R6 set beats clear");
    wr(5'h10, 32'h2000_0000);
    rd(5'h0C, 32'h0000_0001, "R6 cleared");
    @(negedge clk); rx_frame_done = 1; rx_frame_nondata = 0;
    @(negedge clk); rx_frame_done = 0;
    rd(5'h0C, 32'h0000_0001, "R6 data frame no set");

    // R7 error code
    @(negedge clk); err_valid = 1; err_code = 8'h5A;
    @(negedge clk); err_valid = 0; err_code = 8'hFF;
    rd(5'h04, 32'h0000_005A, "R7 error latched");

    // R8 engine flag set beats clear
    @(negedge clk); tx_done = 1; bus_addr = 5'h10; bus_wdata = 32'h8000_0000; bus_wr = 1;
    @(negedge clk); tx_done = 0; bus_wr = 0;
    check(32'(irq), 32'h1, "R8 set beats clear");
    wr(5'h10, 32'h8000_0000);
    check(32'(irq), 32'h0, "R8 engine cleared");

    // R10 unmapped and idle read data
    rd(5'h00, 32'h0, "R10 unmapped read");
    rd(5'h10, 32'h0, "R10 clear reads zero");
    idle(1);
    check(bus_rdata, 32'h0, "R10 idle data zero");

    // R9 hardware reset
    @(negedge clk); rx_word_inc = 1; tx_done = 1; idle(1); rx_word_inc = 0; tx_done = 0;
    wr(5'h08, 32'hE000_0077);
    check(32'(eng_rst), 32'h1, "R9 reset pulse");
    check(32'(xfer_start), 32'h0, "R9 no start");
    rx_word_inc = 1; tx_done = 1;
    @(negedge clk); rx_word_inc = 0; tx_done = 0;
    check(32'(eng_rst), 32'h0, "R9 pulse one cycle");
    check(32'(irq), 32'h0, "R9 flags zeroed");
    check({15'h0, xfer_is_data, xfer_len}, 32'h0, "R9 control zeroed");
    check(tx_addr, 32'h8000_2000, "R9 tx area kept");
    check(rxd_addr, 32'h9000_0000, "R9 data area kept");
    rd(5'h0C, 32'h0, "R9 count zeroed");
    rd(5'h04, 32'h0, "R9 error zeroed");

    idle(4);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: actual %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule